// File: doc/BRIEF.md
# Timing-Speculative ALU with Alternating Verification Lanes

This block is a 32-bit integer ALU whose main copy is allowed to run faster than its worst-case path. The main copy takes one operation per clock and returns a speculative result one cycle after the inputs are sampled, so dependent logic sees low latency. Two more copies of the same ALU check that result. Operations alternate between the two checkers. Each checker holds its operands for two clocks, which gives its combinational path a full half-rate period to settle.

A free-running phase bit sends every operation to one of the two checkers. At the end of its two-cycle window, the checker's result is compared with the main result captured for the same operation. The comparison produces a verified stream of valid, error, corrected value and sequence tag, exactly two cycles after the speculative result. A disagreement marks the operation as a timing violation, and the checker's value is the one passed on for recovery. Real timing faults are not modelled. A fault-mask input is XORed into the main result so that mismatches can be forced on chosen operations.

Top module: `spec_alu_verify`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `spec_valid` and `ver_valid` are low. The sequence tag restarts at 0.
- R2: `in_op` encodings: 0 add, 1 subtract (a minus b), 2 AND, 3 OR, 4 XOR, 5 signed set-less-than (result 1 or 0). Codes 6 and 7 yield 0.
- R3: An operation sampled with `in_valid` high at clock edge k appears on `spec_result` after edge k+1. Its value is the R2 function of the operands XOR `fault_mask`.
- R4: Every valid operation produces exactly one `ver_valid` pulse, after edge k+3, which is two cycles after its speculative result. No other cycle has `ver_valid` high.
- R5: `ver_err` is high exactly when the speculative result differed from the checker result, which here means a nonzero `fault_mask` was applied.
- R6: `ver_result` always carries the fault-free R2 value, whatever the mask.
- R7: The tag starts at 0 and rises by one, modulo 2^TAG_W, for each valid operation. The same tag is shown on `spec_tag` and later on `ver_tag`.
- R8: Operations issued on every consecutive clock are all verified correctly, with none lost or mixed up between the two checkers.
- R9: Add and subtract wrap modulo 2^32. Set-less-than compares as signed, so 0xFFFFFFFF is less than 1.
- R10: A cycle with `in_valid` low produces no output pulse and does not advance the tag, whatever its operands or mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Opcode (R2) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| fault_mask | input | 32 | XOR mask applied to the main result (test) |
| spec_valid | output | 1 | Speculative result valid |
| spec_result | output | 32 | Speculative main-ALU result |
| spec_tag | output | 4 | Tag of the speculative result |
| ver_valid | output | 1 | Verified result valid |
| ver_err | output | 1 | Timing violation detected |
| ver_result | output | 32 | Corrected (checker) result |
| ver_tag | output | 4 | Tag of the verified result |

## Verification
An operation driven before clock edge k has its speculative result due after edge k+1 and its verified result due after edge k+3. The bench drives each operation half a cycle before its edge and records the expected values by issue index. At each falling edge it compares the speculative outputs with the entry issued two iterations earlier and the verified outputs with the entry issued four iterations earlier. Idle entries are included, so an output pulse that arrives early, late or spuriously fails the check.

// File: rtl/spec_alu_pkg.sv
package spec_alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SLT = 3'd5
  } alu_op_e;

  localparam int NUM_LANES = 2;
endpackage

// File: rtl/spec_alu_core.sv
module spec_alu_core
  import spec_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);
  logic slt_bit;

  always_comb slt_bit = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SLT:  y = {{(W-1){1'b0}}, slt_bit};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/spec_alu_lane.sv
// One checker copy: operands are captured on this lane's phase edge and held
// two cycles; the result is sampled at the close of that window.
module spec_alu_lane
  import spec_alu_pkg::*;
#(
  parameter int W       = 32,
  parameter int LANE_ID = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            phase,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  output logic            res_valid,
  output logic [W-1:0]    res_value
);
  localparam logic MY_PHASE = LANE_ID[0];

  logic            hold_v;
  logic [OP_W-1:0] hold_op;
  logic [W-1:0]    hold_a, hold_b;
  logic [W-1:0]    slow_y;
  logic            my_turn;

  always_comb my_turn = (phase == MY_PHASE);

  spec_alu_core #(.W(W)) u_core (
    .op(hold_op), .a(hold_a), .b(hold_b), .y(slow_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_op   <= '0;
      hold_a    <= '0;
      hold_b    <= '0;
      res_valid <= 1'b0;
      res_value <= '0;
    end else if (my_turn) begin
      res_valid <= hold_v;
      res_value <= slow_y;
      hold_v    <= in_valid;
      hold_op   <= in_op;
      hold_a    <= in_a;
      hold_b    <= in_b;
    end
  end
endmodule

// File: rtl/spec_alu_compare.sv
// Slow-rate comparator: captures the main result for the operation whose
// checker window is closing, then compares against that checker next cycle.
module spec_alu_compare
  import spec_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int TAG_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 phase,
  input  logic                 main_valid,
  input  logic [W-1:0]         main_value,
  input  logic [TAG_W-1:0]     main_tag,
  input  logic [NUM_LANES-1:0] lane_valid,
  input  logic [W-1:0]         lane_value [NUM_LANES],
  output logic                 ver_valid,
  output logic                 ver_err,
  output logic [W-1:0]         ver_result,
  output logic [TAG_W-1:0]     ver_tag
);
  logic             cap_v;
  logic [W-1:0]     cap_value;
  logic [TAG_W-1:0] cap_tag;
  logic             sel;
  logic             chk_v;
  logic [W-1:0]     chk_value;

  // The lane whose window closed at the previous edge is the one not in phase now.
  always_comb begin
    sel       = ~phase;
    chk_v     = lane_valid[sel];
    chk_value = lane_value[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_v      <= 1'b0;
      cap_value  <= '0;
      cap_tag    <= '0;
      ver_valid  <= 1'b0;
      ver_err    <= 1'b0;
      ver_result <= '0;
      ver_tag    <= '0;
    end else begin
      cap_v      <= main_valid;
      cap_value  <= main_value;
      cap_tag    <= main_tag;
      ver_valid  <= chk_v & cap_v;
      ver_err    <= chk_v & cap_v & (chk_value != cap_value);
      ver_result <= chk_value;
      ver_tag    <= cap_tag;
    end
  end
endmodule

// File: rtl/spec_alu_verify.sv
module spec_alu_verify
  import spec_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [W-1:0]     fault_mask,
  output logic             spec_valid,
  output logic [W-1:0]     spec_result,
  output logic [TAG_W-1:0] spec_tag,
  output logic             ver_valid,
  output logic             ver_err,
  output logic [W-1:0]     ver_result,
  output logic [TAG_W-1:0] ver_tag
);
  logic             phase;
  logic [TAG_W-1:0] tag_ctr;

  logic             m_v;
  logic [OP_W-1:0]  m_op;
  logic [W-1:0]     m_a, m_b, m_mask;
  logic [TAG_W-1:0] m_tag;
  logic [W-1:0]     fast_y;

  logic [NUM_LANES-1:0] lane_v;
  logic [W-1:0]         lane_y [NUM_LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      tag_ctr <= '0;
    end else begin
      phase <= ~phase;
      if (in_valid) tag_ctr <= tag_ctr + 1'b1;
    end
  end

  // Main (speculative) copy: registered operands, one result per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      m_v    <= 1'b0;
      m_op   <= '0;
      m_a    <= '0;
      m_b    <= '0;
      m_mask <= '0;
      m_tag  <= '0;
    end else begin
      m_v    <= in_valid;
      m_op   <= in_op;
      m_a    <= in_a;
      m_b    <= in_b;
      m_mask <= fault_mask;
      m_tag  <= tag_ctr;
    end
  end

  spec_alu_core #(.W(W)) u_main (
    .op(m_op), .a(m_a), .b(m_b), .y(fast_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_valid  <= 1'b0;
      spec_result <= '0;
      spec_tag    <= '0;
    end else begin
      spec_valid  <= m_v;
      spec_result <= fast_y ^ m_mask;
      spec_tag    <= m_tag;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    spec_alu_lane #(.W(W), .LANE_ID(g)) u_lane (
      .clk(clk), .rst(rst), .phase(phase),
      .in_valid(in_valid), .in_op(in_op), .in_a(in_a), .in_b(in_b),
      .res_valid(lane_v[g]), .res_value(lane_y[g])
    );
  end

  spec_alu_compare #(.W(W), .TAG_W(TAG_W)) u_cmp (
    .clk(clk), .rst(rst), .phase(phase),
    .main_valid(spec_valid), .main_value(spec_result), .main_tag(spec_tag),
    .lane_valid(lane_v), .lane_value(lane_y),
    .ver_valid(ver_valid), .ver_err(ver_err),
    .ver_result(ver_result), .ver_tag(ver_tag)
  );
endmodule

// File: rtl/spec_alu_verify_sva.sv
module spec_alu_verify_sva #(
  parameter int W     = 32,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             spec_valid,
  input logic [W-1:0]     spec_result,
  input logic [TAG_W-1:0] spec_tag,
  input logic             ver_valid,
  input logic             ver_err,
  input logic [W-1:0]     ver_result,
  input logic [TAG_W-1:0] ver_tag
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!spec_valid && !ver_valid));

  p_spec_latency_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 spec_valid);

  p_ver_follows_r4: assert property (@(posedge clk) disable iff (rst)
    spec_valid |-> ##2 ver_valid);

  p_no_stray_ver_r10: assert property (@(posedge clk) disable iff (rst)
    !spec_valid |-> ##2 !ver_valid);

  p_tag_carried_r7: assert property (@(posedge clk) disable iff (rst)
    spec_valid |-> ##2 (ver_tag == $past(spec_tag, 2)));

  p_clean_match_r5: assert property (@(posedge clk) disable iff (rst)
    (ver_valid && !ver_err) |-> (ver_result == $past(spec_result, 2)));

  p_err_differs_r6: assert property (@(posedge clk) disable iff (rst)
    (ver_valid && ver_err) |-> (ver_result != $past(spec_result, 2)));
endmodule

bind spec_alu_verify spec_alu_verify_sva #(.W(W), .TAG_W(TAG_W)) sva_i (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .spec_valid(spec_valid), .spec_result(spec_result), .spec_tag(spec_tag),
  .ver_valid(ver_valid), .ver_err(ver_err), .ver_result(ver_result),
  .ver_tag(ver_tag)
);

// File: tb/spec_alu_verify_tb.sv
module spec_alu_verify_tb_top;
  localparam int W = 32;
  localparam int TAG_W = 4;
  localparam int N = 600;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [2:0] in_op;
  logic [W-1:0] in_a, in_b, fault_mask;
  logic spec_valid, ver_valid, ver_err;
  logic [W-1:0] spec_result, ver_result;
  logic [TAG_W-1:0] spec_tag, ver_tag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic         s_v    [N];
  logic [2:0]   s_op   [N];
  logic [W-1:0] s_a    [N];
  logic [W-1:0] s_b    [N];
  logic [W-1:0] s_mask [N];
  logic [TAG_W-1:0] s_tag [N];

  always #2 clk = ~clk;

  spec_alu_verify #(.W(W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .fault_mask(fault_mask),
    .spec_valid(spec_valid), .spec_result(spec_result), .spec_tag(spec_tag),
    .ver_valid(ver_valid), .ver_err(ver_err), .ver_result(ver_result),
    .ver_tag(ver_tag)
  );

  function automatic logic [W-1:0] golden(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return ($signed(a) < $signed(b)) ? 1 : 0;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_op(int i, logic v, logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] m);
    s_v[i] = v; s_op[i] = op; s_a[i] = a; s_b[i] = b; s_mask[i] = m;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed_sink;
    logic [TAG_W-1:0] tcount;
    seed_sink = $urandom(32'd4242);
    // directed corners (R9, R2, R10, R5, R6)
    set_op(0, 1, 3'd0, 32'hFFFF_FFFF, 32'h1, 0);           // R9 add wrap -> 0
    set_op(1, 1, 3'd1, 32'h0, 32'h1, 0);                   // R9 sub wrap
    set_op(2, 1, 3'd5, 32'hFFFF_FFFF, 32'h1, 0);           // R9 slt -> 1
    set_op(3, 1, 3'd5, 32'h1, 32'hFFFF_FFFF, 0);           // R9 slt -> 0
    set_op(4, 1, 3'd6, 32'h1234, 32'h5678, 0);             // R2 unused code -> 0
    set_op(5, 1, 3'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 32'h1); // R5 injected
    set_op(6, 0, 3'd0, 32'hDEAD, 32'hBEEF, 32'hFFFF);      // R10 idle with mask
    set_op(7, 1, 3'd4, 32'hAAAA_5555, 32'hFFFF_0000, 32'h8000_0000); // R6
    set_op(8, 1, 3'd3, 32'h1, 32'h2, 0);
    for (int i = 9; i < N; i++) begin
      logic v;
      v = (i < 60) ? 1'b1 : ($urandom % 4 != 0);          // R8 back-to-back run
      set_op(i, v, 3'($urandom % 8), $urandom, $urandom,
             ($urandom % 5 == 0) ? W'($urandom | 1) : '0);
    end
    tcount = '0;
    for (int i = 0; i < N; i++) begin
      s_tag[i] = tcount;
      if (s_v[i]) tcount = tcount + 1'b1;
    end

    rst = 1; in_valid = 0; in_op = 0; in_a = 0; in_b = 0; fault_mask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 spec_valid in reset", W'(spec_valid), 0);
    chk("R1 ver_valid in reset", W'(ver_valid), 0);
    rst = 0;

    for (int cyc = 0; cyc < N + 5; cyc++) begin
      if (cyc == 1) begin
        chk("R1 spec_valid after reset", W'(spec_valid), 0);
        chk("R1 ver_valid after reset", W'(ver_valid), 0);
      end
      if (cyc >= 2 && cyc - 2 < N) begin
        int j;
        j = cyc - 2;
        chk("R3/R10 spec_valid", W'(spec_valid), W'(s_v[j]));
        if (s_v[j]) begin
          chk("R3 spec_result", spec_result, golden(s_op[j], s_a[j], s_b[j]) ^ s_mask[j]);
          chk("R7 spec_tag", W'(spec_tag), W'(s_tag[j]));
        end
      end
      if (cyc >= 4 && cyc - 4 < N) begin
        int j;
        j = cyc - 4;
        chk("R4/R8/R10 ver_valid", W'(ver_valid), W'(s_v[j]));
        if (s_v[j]) begin
          chk("R5 ver_err", W'(ver_err), W'(s_mask[j] != 0));
          chk("R6/R2 ver_result", ver_result, golden(s_op[j], s_a[j], s_b[j]));
          chk("R7 ver_tag", W'(ver_tag), W'(s_tag[j]));
        end
      end
      if (cyc < N) begin
        in_valid = s_v[cyc]; in_op = s_op[cyc]; in_a = s_a[cyc];
        in_b = s_b[cyc]; fault_mask = s_mask[cyc];
      end else begin
        in_valid = 0; fault_mask = 0;
      end
      @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule